// File: doc/BRIEF.md
# Key Debouncer with Brightness Chord

This block filters five active-low push keys. Each key has its own eight-bit sample history, which moves one place on every pulse of a periodic sample strobe. The strobe is meant to run at the display slot rate of 1200 Hz. A key counts as newly pressed only when its history shows seven released samples followed by one pressed sample. That event sets a sticky flag, and the flag stays set until software clears it with a per-bit strobe. The block also reports each key's debounced level, taken from the newest sample.

The block also holds a 4-bit display brightness. While the left and right keys are both held, a new press of the up key raises the brightness by one step and a new press of the down key lowers it by one step. The value stops at both ends and does not wrap. Whenever the value really moves, a one-cycle pulse is raised so that an outside agent can store the new setting in non-volatile memory.

There is no data stream here. Every pin is a plain level or strobe, so the block has no valid/ready handshake and no back-pressure. The key inputs must already be synchronous to `clk`.

Top module: `key_debounce_chord`

## Requirements
- R1: During and directly after reset, `edge_flags` and `key_down` read zero, `bright` reads BRIGHT_INIT (default 8) and `bright_chg` is low. Every history register resets to all ones, which means released.
- R2: A history register moves only on a clock edge where `sample_tick` is high. It shifts left and takes the raw key value into bit 0. `key_down[k]` is the inverse of that newest bit and changes on the same edge. With `sample_tick` low, `key_down` and `bright` hold.
- R3: The flag bit of a key is set on the sampling edge where its updated history equals 8'b1111_1110. A press that comes after fewer than seven released samples sets no flag. The key order in `key_n`, `key_down` and `edge_flags` is INT=bit 0, LEFT=bit 1, UP=bit 2, DOWN=bit 3, RIGHT=bit 4.
- R4: Flags are sticky. A flag is cleared only by its `edge_clr` bit being high on a clock edge. If a clear and a new edge meet on the same edge, the flag stays set.
- R5: `edge_flags[7:5]` always read zero, and `edge_clr[7:5]` have no effect.
- R6: On a sampling edge where UP produces an edge and LEFT and RIGHT both read pressed in that same sample, `bright` goes up by one. At 15 it stays at 15.
- R7: On a sampling edge where DOWN produces an edge and LEFT and RIGHT both read pressed in that same sample, `bright` goes down by one. At 0 it stays at 0.
- R8: `bright_chg` is high for exactly the one cycle after an edge on which `bright` took a new value. It stays low when a step is blocked at a limit.
- R9: If UP and DOWN produce edges on the same chorded sample, `bright` stays unchanged and `bright_chg` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle sampling strobe (display slot rate) |
| key_n | input | 5 | Raw key lines, 0 = pressed |
| edge_clr | input | 8 | Per-bit clear strobes for the edge flags |
| edge_flags | output | 8 | Sticky press-edge flags, bits 7:5 zero |
| key_down | output | 5 | Debounced pressed levels, 1 = pressed |
| bright | output | 4 | Brightness value, 0 to 15 |
| bright_chg | output | 1 | One-cycle pulse when brightness changed |

## Verification
A corrupted history bit is not visible at once. It shows up only when a later press is wrongly flagged or wrongly missed, which can be as many as eight samples afterwards. For that reason a reference model follows the histories sample by sample and compares every output on every clock, so that a missed or false edge is reported on the very edge where it should happen. A wrong brightness or a missing or extra change pulse appears on the edge of the chorded press itself. Stimulus covers bounce, clears that meet a new edge, both saturation limits and simultaneous up and down presses.

// File: rtl/keydb_pkg.sv
package keydb_pkg;
  localparam int KEY_INT   = 0;
  localparam int KEY_LEFT  = 1;
  localparam int KEY_UP    = 2;
  localparam int KEY_DOWN  = 3;
  localparam int KEY_RIGHT = 4;
  localparam int KEY_COUNT = 5;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;
endpackage

// File: rtl/keydb_hist.sv
module keydb_hist #(
  parameter int HIST_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_n,
  output logic pressed,
  output logic now_pressed,
  output logic edge_hit
);
  localparam logic [HIST_W-1:0] EDGE_PAT = {{(HIST_W-1){1'b1}}, 1'b0};

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;

  assign hist_nxt    = {hist_q[HIST_W-2:0], raw_n};
  assign edge_hit    = tick && (hist_nxt == EDGE_PAT);
  assign now_pressed = ~hist_nxt[0];
  assign pressed     = ~hist_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
    end else if (tick) begin
      hist_q <= hist_nxt;
    end
  end
endmodule

// File: rtl/keydb_flags.sv
module keydb_flags #(
  parameter int NUM_KEYS = 5,
  parameter int FLAG_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] set_i,
  input  logic [FLAG_W-1:0]   clr_i,
  output logic [FLAG_W-1:0]   flags_o
);
  logic [FLAG_W-1:0] set_w;
  logic [FLAG_W-1:0] flags_q;

  generate
    if (FLAG_W > NUM_KEYS) begin : g_pad
      assign set_w = {{(FLAG_W-NUM_KEYS){1'b0}}, set_i};
    end else begin : g_nopad
      assign set_w = set_i[FLAG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_w;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/keydb_bright.sv
module keydb_bright #(
  parameter int BRIGHT_W    = 4,
  parameter int BRIGHT_INIT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chord_i,
  input  logic                up_edge_i,
  input  logic                dn_edge_i,
  output logic [BRIGHT_W-1:0] bright_o,
  output logic                chg_o
);
  import keydb_pkg::*;

  localparam logic [BRIGHT_W-1:0] B_MAX  = '1;
  localparam logic [BRIGHT_W-1:0] B_MIN  = '0;
  localparam logic [BRIGHT_W-1:0] B_INIT = BRIGHT_W'(BRIGHT_INIT);

  step_e              step;
  logic [BRIGHT_W-1:0] b_q;
  logic [BRIGHT_W-1:0] b_nxt;
  logic                chg_q;

  always_comb begin
    step = STEP_NONE;
    if (chord_i && up_edge_i && !dn_edge_i) step = STEP_UP;
    if (chord_i && dn_edge_i && !up_edge_i) step = STEP_DOWN;
  end

  always_comb begin
    b_nxt = b_q;
    case (step)
      STEP_UP:   if (b_q != B_MAX) b_nxt = b_q + 1'b1;
      STEP_DOWN: if (b_q != B_MIN) b_nxt = b_q - 1'b1;
      default:   b_nxt = b_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q   <= B_INIT;
      chg_q <= 1'b0;
    end else begin
      b_q   <= b_nxt;
      chg_q <= (b_nxt != b_q);
    end
  end

  assign bright_o = b_q;
  assign chg_o    = chg_q;
endmodule

// File: rtl/key_debounce_chord.sv
module key_debounce_chord #(
  parameter int NUM_KEYS    = keydb_pkg::KEY_COUNT,
  parameter int HIST_W      = 8,
  parameter int FLAG_W      = 8,
  parameter int BRIGHT_W    = 4,
  parameter int BRIGHT_INIT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_tick,
  input  logic [NUM_KEYS-1:0] key_n,
  input  logic [FLAG_W-1:0]   edge_clr,
  output logic [FLAG_W-1:0]   edge_flags,
  output logic [NUM_KEYS-1:0] key_down,
  output logic [BRIGHT_W-1:0] bright,
  output logic                bright_chg
);
  import keydb_pkg::*;

  logic [NUM_KEYS-1:0] edge_hit;
  logic [NUM_KEYS-1:0] now_pressed;
  logic                chord;

  generate
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      keydb_hist #(.HIST_W(HIST_W)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (sample_tick),
        .raw_n       (key_n[k]),
        .pressed     (key_down[k]),
        .now_pressed (now_pressed[k]),
        .edge_hit    (edge_hit[k])
      );
    end
  endgenerate

  keydb_flags #(.NUM_KEYS(NUM_KEYS), .FLAG_W(FLAG_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (edge_hit),
    .clr_i   (edge_clr),
    .flags_o (edge_flags)
  );

  assign chord = now_pressed[KEY_LEFT] && now_pressed[KEY_RIGHT];

  keydb_bright #(.BRIGHT_W(BRIGHT_W), .BRIGHT_INIT(BRIGHT_INIT)) u_bright (
    .clk       (clk),
    .rst_n     (rst_n),
    .chord_i   (chord),
    .up_edge_i (edge_hit[KEY_UP]),
    .dn_edge_i (edge_hit[KEY_DOWN]),
    .bright_o  (bright),
    .chg_o     (bright_chg)
  );
endmodule

// File: rtl/keydb_checker.sv
module keydb_checker #(
  parameter int NUM_KEYS = 5,
  parameter int FLAG_W   = 8,
  parameter int BRIGHT_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_tick,
  input logic [FLAG_W-1:0]   edge_clr,
  input logic [FLAG_W-1:0]   edge_flags,
  input logic [NUM_KEYS-1:0] key_down,
  input logic [BRIGHT_W-1:0] bright,
  input logic                bright_chg
);
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_flags[FLAG_W-1:NUM_KEYS] == '0);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_flags & ~edge_clr) & ~edge_flags) == '0));

  p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(key_down) && $stable(bright));

  p_flag_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> ((edge_flags & ~$past(edge_flags)) == '0));

  p_pulse_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bright_chg |-> (bright != $past(bright)));

  p_quiet_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bright_chg |-> (bright == $past(bright)));

  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bright_chg |-> ((bright == BRIGHT_W'($past(bright) + 1'b1)) ||
                    (bright == BRIGHT_W'($past(bright) - 1'b1))));
endmodule

bind key_debounce_chord keydb_checker #(
  .NUM_KEYS(NUM_KEYS), .FLAG_W(FLAG_W), .BRIGHT_W(BRIGHT_W)
) u_keydb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_tick (sample_tick),
  .edge_clr    (edge_clr),
  .edge_flags  (edge_flags),
  .key_down    (key_down),
  .bright      (bright),
  .bright_chg  (bright_chg)
);

// File: tb/tb_key_debounce_chord.sv
module tb_key_debounce_chord;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic [4:0] key_n = 5'h1F;
  logic [7:0] edge_clr = 8'h00;
  logic [7:0] edge_flags;
  logic [4:0] key_down;
  logic [3:0] bright;
  logic       bright_chg;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  int mh[5];
  int mf = 0;
  int mb = 8;
  int mchg = 0;
  int mkd = 0;

  always #5 clk = ~clk;

  key_debounce_chord dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .key_n(key_n),
    .edge_clr(edge_clr), .edge_flags(edge_flags), .key_down(key_down),
    .bright(bright), .bright_chg(bright_chg)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) mh[k] = 255;
      mf = 0; mb = 8; mchg = 0; mkd = 0;
    end else begin
      int e;
      e = 0;
      mchg = 0;
      if (sample_tick) begin
        for (int k = 0; k < 5; k++) begin
          mh[k] = ((mh[k] << 1) | int'(key_n[k])) & 255;
          if (mh[k] == 254) e = e | (1 << k);
        end
        if (key_n[1] == 1'b0 && key_n[4] == 1'b0) begin
          if (e[2] && !e[3] && mb < 15) begin mb = mb + 1; mchg = 1; end
          if (e[3] && !e[2] && mb > 0)  begin mb = mb - 1; mchg = 1; end
        end
      end
      mf = ((mf & ~int'(edge_clr)) | e) & 8'h1F;
      mkd = 0;
      for (int k = 0; k < 5; k++) if ((mh[k] & 1) == 0) mkd = mkd | (1 << k);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3/R4 edge_flags", int'(edge_flags), mf);
      check("R2 key_down", int'(key_down), mkd);
      check("R6/R7 bright", int'(bright), mb);
      check("R8 bright_chg", int'(bright_chg), mchg);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic sample(input logic [4:0] v);
    @(negedge clk);
    key_n = v; sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  // seven released UP/DOWN samples, then one press, with LEFT+RIGHT held
  task automatic chord_stroke(input logic [4:0] press_mask);
    for (int i = 0; i < 7; i++) sample(5'b01101);
    sample(5'b01101 & ~press_mask);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset held
    check("R1 flags in reset", int'(edge_flags), 0);
    check("R1 key_down in reset", int'(key_down), 0);
    check("R1 bright in reset", int'(bright), 8);
    check("R1 bright_chg in reset", int'(bright_chg), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: no tick, key pressed -> nothing moves
    key_n = 5'b11110;
    repeat (3) @(negedge clk);
    check("R2 no tick key_down", int'(key_down), 0);
    check("R3 no tick flags", int'(edge_flags), 0);

    // R3: clean INT press after reset history (all released)
    sample(5'b11110);
    check("R3 INT edge", int'(edge_flags), 1);
    check("R2 INT level", int'(key_down), 1);

    // R4: clear INT flag
    @(negedge clk); edge_clr = 8'h01; @(negedge clk); edge_clr = 8'h00;
    check("R4 cleared", int'(edge_flags), 0);

    // R3 bounce: only three released samples before re-press
    sample(5'b11111); sample(5'b11111); sample(5'b11111);
    sample(5'b11110);
    check("R3 bounce no edge", int'(edge_flags), 0);

    // R4: clear arrives together with a new edge -> set wins
    for (int i = 0; i < 7; i++) sample(5'b11111);
    @(negedge clk);
    key_n = 5'b11110; sample_tick = 1'b1; edge_clr = 8'hFF;
    @(negedge clk);
    sample_tick = 1'b0; edge_clr = 8'h00;
    check("R4 set wins over clear", int'(edge_flags), 1);

    // R5: upper clear bits do nothing, upper flags stay zero
    @(negedge clk); edge_clr = 8'hE0; @(negedge clk); edge_clr = 8'h00;
    check("R5 upper clears ignored", int'(edge_flags), 1);
    @(negedge clk); edge_clr = 8'hFF; @(negedge clk); edge_clr = 8'h00;

    // press LEFT+RIGHT and hold
    sample(5'b01101);
    check("R3 LEFT RIGHT edges", int'(edge_flags), 5'b10010);
    check("R5 upper flags zero", int'(edge_flags) >> 5, 0);

    // R6: up to saturation
    for (int i = 0; i < 9; i++) chord_stroke(5'b00100);
    check("R6 bright saturates high", int'(bright), 15);

    // R7: down to saturation
    for (int i = 0; i < 17; i++) chord_stroke(5'b01000);
    check("R7 bright saturates low", int'(bright), 0);

    for (int i = 0; i < 3; i++) chord_stroke(5'b00100);
    check("R6 bright stepped", int'(bright), 3);

    // R9: UP and DOWN together
    chord_stroke(5'b01100);
    check("R9 simultaneous no change", int'(bright), 3);
    check("R9 no pulse", int'(bright_chg), 0);

    // R6: UP without chord does nothing
    sample(5'b11111);
    for (int i = 0; i < 7; i++) sample(5'b11111);
    sample(5'b11011);
    check("R6 no chord no change", int'(bright), 3);

    repeat (4) @(negedge clk);
    done = 1;
    report();
  end
endmodule